// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits between a processor's load, store and instruction-fetch path and the memory bus. It decides, in the same cycle, whether each access may go out. Software programs a set of regions, eight or sixteen depending on a parameter. Each region has a base address, a power-of-two size, eight sub-regions that can be switched off one at a time, and two permission sets: one for privileged code and one for unprivileged code. Each set has separate read, write and fetch bits.

Every access comes with an address, a type code and a privilege flag. When regions overlap, the matching region with the highest index decides. An access that hits no region is allowed only when a background option is on and the access is privileged. A blocked access is never forwarded. One cycle later the block raises a single-cycle fault pulse and latches the faulting address and type. These stay latched until software clears them. When the unit is globally off, every access passes.

Configuration uses a small write port. A 2-bit register code selects what is written, and a region index picks the region for the per-region registers.

Top module: `region_guard`

## Requirements
- R1: After reset all regions are disabled, the unit is off, `flt_valid` and `flt_pulse` are 0, and every access is forwarded.
- R2: A region covers 2^k bytes, where k is attribute bits [5:1]. The low k bits of the written base are ignored. A region with k below 5 never matches.
- R3: Attribute bits [18:16] give the privileged permissions and bits [21:19] the unprivileged ones, each as {fetch, write, read}. The privilege input selects the set. The access type code is 0 for read, 1 for write, 2 for fetch, and the matching bit of the selected set decides.
- R4: Attribute bits [15:8] switch off sub-regions. Bit j covers the j-th eighth of the region, indexed by address bits [k-1:k-3]. An access in a switched-off sub-region does not match that region.
- R5: When several enabled regions match, the one with the highest index decides.
- R6: An access that matches no region is allowed only if control bit 1 (background) is set and the access is privileged.
- R7: A denied access keeps `bus_valid` low in the same cycle. `flt_pulse` is high for exactly the next cycle.
- R8: On a fault, `flt_addr` and `flt_kind` capture the access one cycle later and `flt_valid` rises. While `flt_valid` is set, later faults do not overwrite the capture.
- R9: A write to register code 3 clears `flt_valid`. A fault in that same cycle is captured as a new record.
- R10: With control bit 0 (enable) clear, every access is forwarded and no fault is raised. Register codes: 0 is region base, 1 is region attribute (bit 0 enables the region), 2 is control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg | input | 2 | Register code: 0 base, 1 attribute, 2 control, 3 clear status |
| cfg_sel | input | $clog2(NREG) | Region index for codes 0 and 1 |
| cfg_wdata | input | AW | Configuration write data |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | AW | Access byte address |
| acc_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access made by privileged code |
| bus_valid | output | 1 | Access forwarded to the bus |
| flt_pulse | output | 1 | One-cycle fault indication |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | AW | Captured faulting address |
| flt_kind | output | 2 | Captured faulting access type |

## Verification
The bound checker watches the handshake properties on every cycle:
- a request is never forwarded unless one is present;
- every blocked request is followed by exactly one fault pulse, and every pulse has a blocked request as its cause;
- a held fault record stays stable until it is cleared;
- everything passes while the unit is off.

Only the bench scenarios can show which accesses the region decode should block. These cover base alignment, size limits, sub-region holes, overlap priority, the background rule and privilege selection, along with the exact address and type captured, including a clear that lands in the same cycle as a new fault.

// File: rtl/rg_pkg.sv
`timescale 1ns/1ps
package rg_pkg;
   localparam logic [1:0] REG_BASE  = 2'd0;
   localparam logic [1:0] REG_ATTR  = 2'd1;
   localparam logic [1:0] REG_CTRL  = 2'd2;
   localparam logic [1:0] REG_CLEAR = 2'd3;

   localparam int ATTR_EN     = 0;
   localparam int ATTR_K_LO   = 1;
   localparam int ATTR_SRD_LO = 8;
   localparam int ATTR_PRM_LO = 16;
   localparam int MIN_K       = 5;

   // permission set: bit 0 read, bit 1 write, bit 2 fetch
   typedef struct packed {
      logic [2:0] usr;
      logic [2:0] prv;
   } perm_t;
endpackage

// File: rtl/rg_region.sv
`timescale 1ns/1ps
module rg_region #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_base,
   input  logic          wr_attr,
   input  logic [AW-1:0] wdata,
   input  logic [AW-1:0] addr,
   output logic          hit,
   output rg_pkg::perm_t perm
);
   import rg_pkg::*;

   logic [AW-1:0] base_q;
   logic          en_q;
   logic [4:0]    k_q;
   logic [7:0]    srd_q;
   perm_t         perm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         en_q   <= 1'b0;
         k_q    <= '0;
         srd_q  <= '0;
         perm_q <= '0;
      end else begin
         if (wr_base) base_q <= wdata;
         if (wr_attr) begin
            en_q   <= wdata[ATTR_EN];
            k_q    <= wdata[ATTR_K_LO +: 5];
            srd_q  <= wdata[ATTR_SRD_LO +: 8];
            perm_q <= perm_t'(wdata[ATTR_PRM_LO +: 6]);
         end
      end
   end

   logic [AW-1:0] keep_mask;
   logic [AW-1:0] diff;
   logic [AW-1:0] sub_shift;
   logic [2:0]    sub_idx;
   logic          size_ok;

   always_comb begin
      keep_mask = {AW{1'b1}} << k_q;
      diff      = (addr ^ base_q) & keep_mask;
      size_ok   = (k_q >= 5'(MIN_K));
      sub_shift = addr >> (k_q - 5'd3);
      sub_idx   = sub_shift[2:0];
      hit       = en_q && size_ok && (diff == '0) && !srd_q[sub_idx];
      perm      = perm_q;
   end
endmodule

// File: rtl/rg_pick.sv
`timescale 1ns/1ps
module rg_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]  hits,
   input  rg_pkg::perm_t perms [N],
   output logic          any,
   output rg_pkg::perm_t win
);
   always_comb begin
      any = 1'b0;
      win = '0;
      for (int i = 0; i < N; i++) begin
         if (hits[i]) begin
            any = 1'b1;
            win = perms[i];
         end
      end
   end
endmodule

// File: rtl/rg_flag.sv
`timescale 1ns/1ps
module rg_flag #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fault_now,
   input  logic [AW-1:0] addr,
   input  logic [1:0]    kind,
   output logic          flt_pulse,
   output logic          flt_valid,
   output logic [AW-1:0] flt_addr,
   output logic [1:0]    flt_kind
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_pulse <= 1'b0;
         flt_valid <= 1'b0;
         flt_addr  <= '0;
         flt_kind  <= '0;
      end else begin
         flt_pulse <= fault_now;
         if (clr) flt_valid <= 1'b0;
         if (fault_now && (clr || !flt_valid)) begin
            flt_valid <= 1'b1;
            flt_addr  <= addr;
            flt_kind  <= kind;
         end
      end
   end
endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard #(
   parameter int NREG = 8,
   parameter int AW   = 32,
   localparam int IW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_reg,
   input  logic [IW-1:0] cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   input  logic [1:0]    acc_kind,
   input  logic          acc_priv,
   output logic          bus_valid,
   output logic          flt_pulse,
   output logic          flt_valid,
   output logic [AW-1:0] flt_addr,
   output logic [1:0]    flt_kind
);
   import rg_pkg::*;

   if (!(NREG == 8 || NREG == 16)) begin : g_bad_nreg
      $error("region_guard: NREG must be 8 or 16");
   end
   if (AW < 22) begin : g_bad_aw
      $error("region_guard: AW must be at least 22");
   end

   logic glob_en, bg_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_en <= 1'b0;
         bg_en   <= 1'b0;
      end else if (cfg_we && cfg_reg == REG_CTRL) begin
         glob_en <= cfg_wdata[0];
         bg_en   <= cfg_wdata[1];
      end
   end

   logic [NREG-1:0] hits;
   perm_t           perms [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic sel_me;
      assign sel_me = cfg_we && (cfg_sel == IW'(g));
      rg_region #(.AW(AW)) u_rgn (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_base (sel_me && cfg_reg == REG_BASE),
         .wr_attr (sel_me && cfg_reg == REG_ATTR),
         .wdata   (cfg_wdata),
         .addr    (acc_addr),
         .hit     (hits[g]),
         .perm    (perms[g])
      );
   end

   logic  any_hit;
   perm_t win;

   rg_pick #(.N(NREG)) u_pick (
      .hits  (hits),
      .perms (perms),
      .any   (any_hit),
      .win   (win)
   );

   logic [2:0] set_sel;
   logic       allow;
   logic       fault_now;

   always_comb begin
      set_sel = acc_priv ? win.prv : win.usr;
      if (!glob_en)     allow = 1'b1;
      else if (any_hit) allow = (acc_kind != 2'd3) && set_sel[acc_kind];
      else              allow = bg_en && acc_priv;
      bus_valid = acc_valid && allow;
      fault_now = acc_valid && !allow;
   end

   rg_flag #(.AW(AW)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (cfg_we && cfg_reg == REG_CLEAR),
      .fault_now (fault_now),
      .addr      (acc_addr),
      .kind      (acc_kind),
      .flt_pulse (flt_pulse),
      .flt_valid (flt_valid),
      .flt_addr  (flt_addr),
      .flt_kind  (flt_kind)
   );
endmodule

// File: rtl/rg_guard_chk.sv
`timescale 1ns/1ps
module rg_guard_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [1:0]    cfg_reg,
   input logic          acc_valid,
   input logic          bus_valid,
   input logic          flt_pulse,
   input logic          flt_valid,
   input logic [AW-1:0] flt_addr,
   input logic [1:0]    flt_kind,
   input logic          glob_en
);
   logic clr;
   assign clr = cfg_we && (cfg_reg == 2'd3);

   a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> acc_valid);

   a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !bus_valid) |=> flt_pulse);

   a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      flt_pulse |-> $past(acc_valid && !bus_valid));

   a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      flt_pulse |-> flt_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !clr) |=> (flt_valid && $stable(flt_addr) && $stable(flt_kind)));

   a_r10_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> (bus_valid == acc_valid));
endmodule

bind region_guard rg_guard_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_reg   (cfg_reg),
   .acc_valid (acc_valid),
   .bus_valid (bus_valid),
   .flt_pulse (flt_pulse),
   .flt_valid (flt_valid),
   .flt_addr  (flt_addr),
   .flt_kind  (flt_kind),
   .glob_en   (glob_en)
);

// File: tb/sim_region_guard.sv
`timescale 1ns/1ps
module sim_region_guard;
   localparam int NREG = 8;
   localparam int AW   = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_reg = '0;
   logic [2:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [1:0]    acc_kind = '0;
   logic          acc_priv = 1'b0;
   logic          bus_valid, flt_pulse, flt_valid;
   logic [AW-1:0] flt_addr;
   logic [1:0]    flt_kind;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   region_guard #(.NREG(NREG), .AW(AW)) u0 (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_attr(input bit en, input int k, input logic [7:0] srd,
                                           input logic [2:0] pp, input logic [2:0] up);
      logic [4:0] kk = k[4:0];
      return {10'd0, up, pp, srd, 2'b00, kk, en};
   endfunction

   task automatic wr(input logic [1:0] r, input logic [2:0] s, input logic [31:0] d);
      cfg_we = 1'b1; cfg_reg = r; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic acc(input string tag, input logic [31:0] a, input logic [1:0] k,
                      input logic p, input bit ok);
      acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
      #2;
      chk({tag, " bus"}, 32'(bus_valid), 32'(ok));
      @(negedge clk);
      acc_valid = 1'b0;
      chk({tag, " pulse"}, 32'(flt_pulse), 32'(!ok));
   endtask

   task automatic t_reset();
      chk("R1 flt_valid", 32'(flt_valid), 0);
      chk("R1 flt_pulse", 32'(flt_pulse), 0);
      acc("R1 off write", 32'h0000_0100, 2'd1, 1'b0, 1'b1);
      acc("R10 off fetch", 32'h2000_0000, 2'd2, 1'b0, 1'b1);
   endtask

   task automatic t_basic();
      wr(2'd0, 3'd0, 32'h2000_0000);
      wr(2'd1, 3'd0, mk_attr(1, 12, 8'h00, 3'b011, 3'b001));
      wr(2'd2, 3'd0, 32'h1);
      acc("R3 priv read", 32'h2000_0010, 2'd0, 1'b1, 1'b1);
      acc("R2 top byte user read", 32'h2000_0FFC, 2'd0, 1'b0, 1'b1);
      acc("R3 user write denied", 32'h2000_0010, 2'd1, 1'b0, 1'b0);
      chk("R8 valid", 32'(flt_valid), 1);
      chk("R8 addr", flt_addr, 32'h2000_0010);
      chk("R8 kind", 32'(flt_kind), 1);
      acc("R3 priv fetch denied", 32'h2000_0020, 2'd2, 1'b1, 1'b0);
      chk("R8 addr kept", flt_addr, 32'h2000_0010);
      chk("R8 kind kept", 32'(flt_kind), 1);
      acc("R6 miss no bg", 32'h2000_1000, 2'd0, 1'b1, 1'b0);
      wr(2'd3, 3'd0, 32'h0);
      chk("R9 cleared", 32'(flt_valid), 0);
   endtask

   task automatic t_align();
      wr(2'd0, 3'd1, 32'h3000_0123);
      wr(2'd1, 3'd1, mk_attr(1, 8, 8'h00, 3'b111, 3'b111));
      acc("R2 low bits ignored", 32'h3000_01F0, 2'd1, 1'b0, 1'b1);
      acc("R2 region start", 32'h3000_0100, 2'd0, 1'b0, 1'b1);
      acc("R2 past end", 32'h3000_0200, 2'd0, 1'b0, 1'b0);
      chk("R8 addr", flt_addr, 32'h3000_0200);
      chk("R8 kind read", 32'(flt_kind), 0);
      wr(2'd0, 3'd4, 32'h5000_0000);
      wr(2'd1, 3'd4, mk_attr(1, 4, 8'h00, 3'b111, 3'b111));
      wr(2'd3, 3'd0, 32'h0);
      acc("R2 tiny never matches", 32'h5000_0000, 2'd0, 1'b1, 1'b0);
      wr(2'd3, 3'd0, 32'h0);
   endtask

   task automatic t_overlap();
      wr(2'd2, 3'd0, 32'h3);
      wr(2'd0, 3'd3, 32'h4000_0000);
      wr(2'd1, 3'd3, mk_attr(1, 16, 8'h00, 3'b111, 3'b111));
      wr(2'd0, 3'd5, 32'h4000_0000);
      wr(2'd1, 3'd5, mk_attr(1, 8, 8'h08, 3'b111, 3'b000));
      acc("R5 higher index denies", 32'h4000_0010, 2'd0, 1'b0, 1'b0);
      wr(2'd3, 3'd0, 32'h0);
      acc("R5 only lower matches", 32'h4000_0100, 2'd0, 1'b0, 1'b1);
      acc("R4 hole falls through", 32'h4000_0064, 2'd0, 1'b0, 1'b1);
      wr(2'd1, 3'd3, mk_attr(0, 16, 8'h00, 3'b111, 3'b111));
      acc("R4 hole user miss", 32'h4000_0064, 2'd0, 1'b0, 1'b0);
      acc("R6 bg priv allowed", 32'h4000_0064, 2'd0, 1'b1, 1'b1);
      acc("R3 priv fetch region5", 32'h4000_0010, 2'd2, 1'b1, 1'b1);
      wr(2'd3, 3'd0, 32'h0);
   endtask

   task automatic t_clear_race();
      acc("R7 user read denied", 32'h4000_0020, 2'd0, 1'b0, 1'b0);
      chk("R8 addr A", flt_addr, 32'h4000_0020);
      cfg_we = 1'b1; cfg_reg = 2'd3;
      acc_valid = 1'b1; acc_addr = 32'h4000_0030; acc_kind = 2'd1; acc_priv = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      chk("R9 race valid", 32'(flt_valid), 1);
      chk("R9 race addr", flt_addr, 32'h4000_0030);
      chk("R9 race kind", 32'(flt_kind), 1);
   endtask

   task automatic t_off();
      wr(2'd2, 3'd0, 32'h2);
      acc("R10 off passes", 32'h4000_0010, 2'd1, 1'b0, 1'b1);
      chk("R10 status untouched", flt_addr, 32'h4000_0030);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_align();
      t_overlap();
      t_clear_race();
      t_off();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule